// File: doc/BRIEF.md
# Dual-Mode Compare-Match PWM Timer

This block is a free-running 16-bit up-counter with four compare registers (A, B, C, D) that turn counter matches into pulse-width-modulated outputs. Each compare register has its own small action field. That field says what a match does to an output: nothing, drive low, drive high or toggle. It also holds an initial level. Any compare register can be chosen as the counter-clear source, and the value in that register then sets the PWM period.

Two operating modes share the same registers. In paired mode, A and B together steer output 0 and C and D together steer output 2. One register of each pair typically sets the edge and the other resets it. In multi-phase mode, the register picked as the clear source is the period register. Every other register is a duty register with an output of its own. On each period clear, every duty output returns to its initial level.

The counter advances only in cycles where the prescaled `count_en` input is high. Software or a sequencer loads the registers through a plain write port. The port has no handshake, and a write lands on the next clock edge.

Top module: `cmpwm_timer`

## Requirements
- R1: After reset the count is 0, every output is low, all compare registers are 0 and all action fields are 0.
- R2: The count rises by one on each clock where `count_en` is high and no clear occurs. It holds its value while `count_en` is low.
- R3: When `count_en` is high and the count equals the register chosen by `clr_sel` (0=A, 1=B, 2=C, 3=D), the count is 0 after the next clock edge. This makes the period that register value plus one.
- R4: A match is the count equalling a compare register while `count_en` is high. Outputs change only on the clock that follows a match. Action code bits [1:0] mean: 00 no change, 01 drive 0, 10 drive 1, 11 toggle. With `count_en` low and `mode` and `clr_sel` steady, outputs hold.
- R5: In paired mode (`mode`=0), matches on A and B act on `pwm_o[0]`, and matches on C and D act on `pwm_o[2]`. `pwm_o[1]` and `pwm_o[3]` stay low.
- R6: In paired mode, if both registers of a pair hold the same value, matches leave that pair's output unchanged.
- R7: In multi-phase mode (`mode`=1), each register other than the period register drives `pwm_o` at its own index. The output at the period register's index stays low.
- R8: In multi-phase mode, a period clear sets every duty output to the initial level in bit 3 of its action field. This overrides any action from a match in the same cycle.
- R9: In multi-phase mode, a duty register equal to the period register causes no output change on its match, so its output stays at its initial level for the whole period. Together with the action codes, this makes both 0 % and 100 % duty reachable.
- R10: On the clock after `mode` changes, outputs take their initial levels. In paired mode `pwm_o[0]` takes bit 3 of A's field and `pwm_o[2]` takes bit 3 of C's field. In multi-phase mode each duty output takes bit 3 of its own field.
- R11: A write with `wr_en` high stores into the location given by `wr_addr`. Addresses 0..3 hold compare registers A..D (full `wr_data`). Addresses 4..7 hold action fields A..D (`wr_data[3:0]`). The new value is in use from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_en | input | 1 | Prescaled count enable |
| mode | input | 1 | 0 = paired mode, 1 = multi-phase mode |
| clr_sel | input | 2 | Compare register that clears the counter (period register) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0..3 compare A..D, 4..7 action A..D |
| wr_data | input | 16 | Write data |
| cnt_o | output | 16 | Current count |
| pwm_o | output | 4 | Waveform outputs, one per compare register index |

## Verification
The hardest situation to create is a period clear that coincides with a duty register holding the same value as the period register, right after a switch into multi-phase mode. In that situation, initial-level loading, the equal-value suppression and the clear override all act on the same outputs. The stimulus loads every register and action field while `count_en` is low. It then flips `mode` with the counter frozen, so the mode-entry levels can be observed in isolation. Counting is enabled only after that, and the outputs are sampled exactly at the duty edges and at the period wrap.

// File: rtl/cmpwm_pkg.sv
package cmpwm_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } act_e;

  // Resulting pin level after one match action
  function automatic logic act_apply(input logic cur, input logic [1:0] code);
    logic res;
    case (act_e'(code))
      ACT_LOW:  res = 1'b0;
      ACT_HIGH: res = 1'b1;
      ACT_FLIP: res = ~cur;
      default:  res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/cmpwm_regs.sv
module cmpwm_regs #(
  parameter int CNT_W = 16,
  parameter int NREG  = 4,
  parameter int ACT_W = 4,
  localparam int AW   = $clog2(2 * NREG)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [CNT_W-1:0]            wr_data,
  output logic [NREG-1:0][CNT_W-1:0]  cmp_v,
  output logic [NREG-1:0][1:0]        code_v,
  output logic [NREG-1:0]             init_v
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_v[i]  <= '0;
        code_v[i] <= '0;
        init_v[i] <= 1'b0;
      end else if (wr_en) begin
        if (wr_addr == AW'(i))
          cmp_v[i] <= wr_data;
        if (wr_addr == AW'(NREG + i)) begin
          code_v[i] <= wr_data[1:0];
          init_v[i] <= wr_data[ACT_W-1];
        end
      end
    end
  end

endmodule

// File: rtl/cmpwm_counter.sv
module cmpwm_counter #(
  parameter int CNT_W = 16,
  parameter int NREG  = 4,
  localparam int SW   = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       count_en,
  input  logic [NREG-1:0][CNT_W-1:0] cmp_v,
  input  logic [SW-1:0]              clr_sel,
  output logic [CNT_W-1:0]           cnt,
  output logic [NREG-1:0]            match,
  output logic                       clr_hit
);

  for (genvar i = 0; i < NREG; i++) begin : g_cmp
    assign match[i] = count_en && (cnt == cmp_v[i]);
  end

  assign clr_hit = match[clr_sel];

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (count_en)
      cnt <= clr_hit ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/cmpwm_outctl.sv
module cmpwm_outctl
  import cmpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NREG  = 4,
  localparam int SW    = $clog2(NREG),
  localparam int NPAIR = NREG / 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode,
  input  logic [SW-1:0]              clr_sel,
  input  logic [NREG-1:0]            match,
  input  logic                       clr_hit,
  input  logic [NREG-1:0][CNT_W-1:0] cmp_v,
  input  logic [NREG-1:0][1:0]       code_v,
  input  logic [NREG-1:0]            init_v,
  output logic [NREG-1:0]            pwm
);

  logic            mode_q;
  logic            entry;
  logic [NREG-1:0] nxt;

  assign entry = (mode != mode_q);

  always_comb begin
    nxt = pwm;
    if (!mode) begin
      // paired: even index is the pin, odd index is its partner
      for (int k = 0; k < NPAIR; k++) begin
        nxt[2*k+1] = 1'b0;
        if (entry) begin
          nxt[2*k] = init_v[2*k];
        end else if (cmp_v[2*k] != cmp_v[2*k+1]) begin
          if (match[2*k])
            nxt[2*k] = act_apply(nxt[2*k], code_v[2*k]);
          if (match[2*k+1])
            nxt[2*k] = act_apply(nxt[2*k], code_v[2*k+1]);
        end
      end
    end else begin
      // multi-phase: clear and entry outrank the duty action
      for (int i = 0; i < NREG; i++) begin
        if (SW'(i) == clr_sel)
          nxt[i] = 1'b0;
        else if (entry || clr_hit)
          nxt[i] = init_v[i];
        else if (match[i] && (cmp_v[i] != cmp_v[clr_sel]))
          nxt[i] = act_apply(pwm[i], code_v[i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      pwm    <= '0;
    end else begin
      mode_q <= mode;
      pwm    <= nxt;
    end
  end

endmodule

// File: rtl/cmpwm_timer.sv
module cmpwm_timer #(
  parameter int CNT_W = 16,
  parameter int NREG  = 4,
  parameter int ACT_W = 4,
  localparam int AW   = $clog2(2 * NREG),
  localparam int SW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             mode,
  input  logic [SW-1:0]    clr_sel,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic [NREG-1:0]  pwm_o
);

  logic [NREG-1:0][CNT_W-1:0] cmp_v;
  logic [NREG-1:0][1:0]       code_v;
  logic [NREG-1:0]            init_v;
  logic [NREG-1:0]            match;
  logic                       clr_hit;

  cmpwm_regs #(.CNT_W(CNT_W), .NREG(NREG), .ACT_W(ACT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cmp_v   (cmp_v),
    .code_v  (code_v),
    .init_v  (init_v)
  );

  cmpwm_counter #(.CNT_W(CNT_W), .NREG(NREG)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (count_en),
    .cmp_v    (cmp_v),
    .clr_sel  (clr_sel),
    .cnt      (cnt_o),
    .match    (match),
    .clr_hit  (clr_hit)
  );

  cmpwm_outctl #(.CNT_W(CNT_W), .NREG(NREG)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .clr_sel (clr_sel),
    .match   (match),
    .clr_hit (clr_hit),
    .cmp_v   (cmp_v),
    .code_v  (code_v),
    .init_v  (init_v),
    .pwm     (pwm_o)
  );

endmodule

// File: rtl/cmpwm_chk.sv
module cmpwm_chk #(
  parameter int CNT_W = 16,
  parameter int NREG  = 4,
  localparam int SW   = $clog2(NREG)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             count_en,
  input logic             mode,
  input logic [SW-1:0]    clr_sel,
  input logic [CNT_W-1:0] cnt_o,
  input logic [NREG-1:0]  pwm_o,
  input logic             clr_hit,
  input logic [NREG-1:0]  init_v
);

  function automatic logic [NREG-1:0] odd_bits();
    logic [NREG-1:0] m;
    m = '0;
    for (int i = 1; i < NREG; i += 2) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [NREG-1:0] ODD_M = odd_bits();

  logic [NREG-1:0] pmask;
  assign pmask = NREG'(1) << clr_sel;

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |=> ((cnt_o == CNT_W'($past(cnt_o) + 1'b1)) || (cnt_o == '0)));

  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> $stable(cnt_o));

  p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (cnt_o == '0));

  p_quiet_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && $stable(mode) && $stable(clr_sel)) |=> $stable(pwm_o));

  p_spare_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |=> ((pwm_o & ODD_M) == '0));

  p_period_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode |=> (pwm_o[$past(clr_sel)] == 1'b0));

  p_clear_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && clr_hit) |=> (((pwm_o ^ $past(init_v)) & ~$past(pmask)) == '0));

endmodule

bind cmpwm_timer cmpwm_chk #(.CNT_W(CNT_W), .NREG(NREG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .count_en (count_en),
  .mode     (mode),
  .clr_sel  (clr_sel),
  .cnt_o    (cnt_o),
  .pwm_o    (pwm_o),
  .clr_hit  (clr_hit),
  .init_v   (init_v)
);

// File: tb/cmpwm_timer_tb.sv
module cmpwm_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        count_en = 1'b0;
  logic        mode = 1'b0;
  logic [1:0]  clr_sel = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt_o;
  logic [3:0]  pwm_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cmpwm_timer u_dut (
    .clk (clk), .rst_n (rst_n), .count_en (count_en), .mode (mode),
    .clr_sel (clr_sel), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .cnt_o (cnt_o), .pwm_o (pwm_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; count_en = 1'b0; mode = 1'b0; clr_sel = '0; wr_en = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    step(1);
    check("R1 count", 32'(cnt_o), 0);
    check("R1 outputs", 32'(pwm_o), 0);
  endtask

  task automatic t_count_hold();
    do_reset();
    wr(3, 16'd1000);            // R11: D written before use
    clr_sel = 2'd3;
    count_en = 1'b1;
    step(5);
    check("R2 increment", 32'(cnt_o), 5);
    count_en = 1'b0;
    step(3);
    check("R2 hold", 32'(cnt_o), 5);
  endtask

  task automatic t_clear();
    do_reset();
    clr_sel = 2'd3;
    wr(3, 16'd4);
    count_en = 1'b1;
    step(5);
    check("R3 R11 wrap to zero", 32'(cnt_o), 0);
    step(1);
    check("R3 restart", 32'(cnt_o), 1);
  endtask

  task automatic t_paired();
    do_reset();
    wr(0, 16'd2); wr(1, 16'd5); wr(2, 16'd3); wr(3, 16'd7);
    wr(4, 16'h2); wr(5, 16'h1); wr(6, 16'h3); wr(7, 16'h0);
    clr_sel = 2'd3;
    check("R4 quiet while disabled", 32'(pwm_o), 0);
    count_en = 1'b1;
    step(3);
    check("R4 R5 A drives high", 32'(pwm_o), 32'b0001);
    step(1);
    check("R4 R5 C toggles", 32'(pwm_o), 32'b0101);
    step(2);
    check("R4 R5 B drives low", 32'(pwm_o), 32'b0100);
    step(6);
    check("R4 R5 second period", 32'(pwm_o), 32'b0001);
  endtask

  task automatic t_paired_equal();
    do_reset();
    wr(0, 16'd3); wr(1, 16'd3); wr(2, 16'd2); wr(3, 16'd2);
    wr(4, 16'h3); wr(5, 16'h0); wr(6, 16'h2); wr(7, 16'h2);
    clr_sel = 2'd1;
    count_en = 1'b1;
    step(4);
    check("R6 equal pair unchanged", 32'(pwm_o), 0);
    step(4);
    check("R6 equal pair unchanged 2", 32'(pwm_o), 0);
  endtask

  task automatic t_multi();
    do_reset();
    wr(0, 16'd9); wr(1, 16'd2); wr(2, 16'd9); wr(3, 16'd5);
    wr(5, 16'h9); wr(6, 16'h9); wr(7, 16'h2);
    clr_sel = 2'd0;
    mode = 1'b1;
    step(1);
    check("R10 multi entry levels", 32'(pwm_o), 32'b0110);
    count_en = 1'b1;
    step(3);
    check("R7 B duty edge", 32'(pwm_o), 32'b0100);
    step(3);
    check("R7 D duty edge", 32'(pwm_o), 32'b1100);
    step(3);
    check("R9 C equal period stays", 32'(pwm_o), 32'b1100);
    step(1);
    check("R8 clear restores init", 32'(pwm_o), 32'b0110);
    check("R3 period wrap", 32'(cnt_o), 0);
    count_en = 1'b0;
    wr(4, 16'h8); wr(6, 16'h0);
    mode = 1'b0;
    step(1);
    check("R10 paired entry levels", 32'(pwm_o), 32'b0001);
  endtask

  initial begin
    step(1);
    t_reset();
    t_count_hold();
    t_clear();
    t_paired();
    t_paired_equal();
    t_multi();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule